// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of an N-bit word by a variable number of places in one operation and updates a single carry flag. It offers logical shifts in both directions, an arithmetic right shift, and rotates in both directions. Each rotate comes in two kinds. A plain rotate turns within the word. A carry rotate turns through an (N+1)-bit ring made of the carry flag and the word.

The carry flag takes part in every mode. In the shift and plain-rotate modes it picks up the last bit that crossed the word boundary. In the carry rotates it is the extra ring position. A shift amount of zero and the pass-through code leave both the word and the carry untouched.

The arithmetic is purely combinational. A thin registered stage around it samples the operands on a valid strobe. One clock later it presents the result and the new carry together with a one-cycle done pulse, and it holds them until the next strobe.

Top module: `shrot_reg_top`

## Requirements
- R1: Operation code 0 (logical left) moves bits toward the MSB by the count and fills vacated low bits with 0. For counts 1 to N, the carry out is data[N-count].
- R2: Operation code 1 (logical right) moves bits toward the LSB by the count and fills vacated high bits with 0. For counts 1 to N, the carry out is data[count-1].
- R3: Operation code 2 (arithmetic right) fills vacated high bits with the original sign bit. For counts 1 to N, the carry out is data[count-1].
- R4: Operation code 3 (plain left rotate) feeds bits leaving the MSB into the LSB. For a nonzero count, the carry out equals the resulting LSB.
- R5: Operation code 4 (plain right rotate) feeds bits leaving the LSB into the MSB. For a nonzero count, the carry out equals the resulting MSB.
- R6: Operation code 5 (left rotate through carry) turns the (N+1)-bit ring {carry, data} left. The old carry enters the LSB and the bit leaving the MSB becomes the new carry.
- R7: Operation code 6 (right rotate through carry) turns the ring {carry, data} right. The old carry enters the MSB and the bit leaving the LSB becomes the new carry.
- R8: A count of 0 returns the data unchanged and the incoming carry, in every mode.
- R9: Counts above N give a zero result and a zero carry for the logical shifts. For arithmetic right, any count of N or more gives every result bit and the carry equal to the sign bit.
- R10: Plain rotates use the count modulo N. Carry rotates use the count modulo N+1, so a count equal to N+1 leaves both data and carry unchanged.
- R11: Operation code 7 passes the data and the carry through unchanged for any count.
- R12: A strobe on in_valid at a rising edge puts the result and carry on the outputs after that edge, with out_valid high for exactly that cycle. Without a strobe, out_valid is low and the outputs hold their values.
- R13: While rst_n is low, out_data, out_carry and out_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: sample the operands at this edge |
| in_op | input | 3 | Operation code (0 to 7, see R1 to R11) |
| in_data | input | N | Operand word |
| in_count | input | CW | Number of bit positions to move |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | One-cycle done pulse |
| out_data | output | N | Result word |
| out_carry | output | 1 | Resulting carry flag |

## Verification
The bench uses words with asymmetric bit patterns, such as 0x3B, 0x96 and 0x55. With these, a move in the wrong direction or by one place too many or too few gives a different word. The incoming carry is usually set opposite to the expected carry out, so a carry that is never updated shows up as an error. Single-bit words such as 0x01 and 0x80 check the edge bits and show whether the old carry really enters the ring. Counts of exactly N, above N, N+1 and zero separate modulo-N from modulo-(N+1) wrapping, and saturating shifts from wrapping ones.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_SAR  = 3'd2,
      OP_ROTL = 3'd3,
      OP_ROTR = 3'd4,
      OP_RCL  = 3'd5,
      OP_RCR  = 3'd6,
      OP_PASS = 3'd7
   } shrot_op_e;

endpackage

// File: rtl/shrot_shifter.sv
// Non-wrapping shift. The carry is handled as a bit appended beside the word,
// so a shift by any amount leaves the last bit that left the word there.
module shrot_shifter #(
   parameter int N     = 16,
   parameter int CW    = 5,
   parameter bit RIGHT = 1'b0,
   parameter bit ARITH = 1'b0
) (
   input  logic [N-1:0]  data,
   input  logic [CW-1:0] count,
   output logic [N-1:0]  res,
   output logic          cout
);

   generate
      if (!RIGHT) begin : g_left
         logic [N:0] ext;
         assign ext         = {1'b0, data} << count;
         assign {cout, res} = ext;
      end else if (ARITH) begin : g_sar
         logic signed [N:0] ext;
         assign ext         = $signed({data, 1'b0}) >>> count;
         assign {res, cout} = ext;
      end else begin : g_shr
         logic [N:0] ext;
         assign ext         = {data, 1'b0} >> count;
         assign {res, cout} = ext;
      end
   endgenerate

endmodule

// File: rtl/shrot_rotator.sv
// Wrapping rotate over a ring of N bits (plain) or N+1 bits (through carry).
module shrot_rotator #(
   parameter int N    = 16,
   parameter int CW   = 5,
   parameter bit LEFT = 1'b1,
   parameter bit THRU = 1'b0
) (
   input  logic [N-1:0]  data,
   input  logic          cin,
   input  logic [CW-1:0] count,
   output logic [N-1:0]  res,
   output logic          cout
);

   localparam int W = THRU ? N + 1 : N;

   logic [W-1:0]   ring;
   logic [W-1:0]   turned;
   logic [CW-1:0]  amt;
   logic [2*W-1:0] twice;
   logic [2*W-1:0] moved;

   assign amt   = CW'(32'(count) % 32'(W));
   assign twice = {ring, ring};

   generate
      if (THRU) begin : g_ring_c
         assign ring = {cin, data};
      end else begin : g_ring_p
         assign ring = data;
      end

      if (LEFT) begin : g_left
         assign moved  = twice << amt;
         assign turned = moved[2*W-1:W];
      end else begin : g_right
         assign moved  = twice >> amt;
         assign turned = moved[W-1:0];
      end

      if (THRU) begin : g_out_c
         assign res  = turned[N-1:0];
         assign cout = turned[N];
      end else begin : g_out_p
         assign res  = turned;
         assign cout = LEFT ? turned[0] : turned[N-1];
      end
   endgenerate

endmodule

// File: rtl/shrot_core.sv
module shrot_core
   import shrot_pkg::*;
#(
   parameter int N  = 16,
   parameter int CW = 5
) (
   input  logic [2:0]    op,
   input  logic [N-1:0]  data,
   input  logic [CW-1:0] count,
   input  logic          cin,
   output logic [N-1:0]  res,
   output logic          cout
);

   localparam int NSH  = 3;
   localparam int NROT = 4;

   logic [N-1:0] sh_res  [NSH];
   logic         sh_cy   [NSH];
   logic [N-1:0] rot_res [NROT];
   logic         rot_cy  [NROT];

   // shifter slot i serves operation code i
   for (genvar i = 0; i < NSH; i++) begin : g_sh
      shrot_shifter #(
         .N(N), .CW(CW), .RIGHT(i != 0), .ARITH(i == 2)
      ) shifter_i (
         .data(data), .count(count), .res(sh_res[i]), .cout(sh_cy[i])
      );
   end

   // rotator slot j serves operation code j+3
   for (genvar j = 0; j < NROT; j++) begin : g_rot
      shrot_rotator #(
         .N(N), .CW(CW), .LEFT((j % 2) == 0), .THRU(j >= 2)
      ) rotator_i (
         .data(data), .cin(cin), .count(count),
         .res(rot_res[j]), .cout(rot_cy[j])
      );
   end

   always_comb begin
      res  = data;
      cout = cin;
      if (count != '0) begin
         unique case (shrot_op_e'(op))
            OP_SHL:  begin res = sh_res[0];  cout = sh_cy[0];  end
            OP_SHR:  begin res = sh_res[1];  cout = sh_cy[1];  end
            OP_SAR:  begin res = sh_res[2];  cout = sh_cy[2];  end
            OP_ROTL: begin res = rot_res[0]; cout = rot_cy[0]; end
            OP_ROTR: begin res = rot_res[1]; cout = rot_cy[1]; end
            OP_RCL:  begin res = rot_res[2]; cout = rot_cy[2]; end
            OP_RCR:  begin res = rot_res[3]; cout = rot_cy[3]; end
            OP_PASS: begin res = data;       cout = cin;       end
         endcase
      end
   end

endmodule

// File: rtl/shrot_reg_top.sv
module shrot_reg_top
   import shrot_pkg::*;
#(
   parameter int N  = 16,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [2:0]    in_op,
   input  logic [N-1:0]  in_data,
   input  logic [CW-1:0] in_count,
   input  logic          in_carry,
   output logic          out_valid,
   output logic [N-1:0]  out_data,
   output logic          out_carry
);

   generate
      if (N < 2) begin : g_bad_width
         $error("shrot_reg_top: N must be at least 2");
      end
      if ((1 << CW) <= N + 1) begin : g_bad_count
         $error("shrot_reg_top: CW too narrow to express counts above N");
      end
   endgenerate

   logic [N-1:0] core_res;
   logic         core_cy;

   shrot_core #(.N(N), .CW(CW)) core_i (
      .op(in_op), .data(in_data), .count(in_count), .cin(in_carry),
      .res(core_res), .cout(core_cy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_carry <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data  <= core_res;
            out_carry <= core_cy;
         end
      end
   end

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_carry)));
   assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_count == '0) |=>
         (out_data == $past(in_data) && out_carry == $past(in_carry)));
   assert_pass_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd7) |=>
         (out_data == $past(in_data) && out_carry == $past(in_carry)));
   assert_shl_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd0 && in_count > CW'(N)) |=>
         (out_data == '0 && !out_carry));
   assert_sar_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd2 && in_count >= CW'(N)) |=>
         (out_data == {N{$past(in_data[N-1])}} && out_carry == $past(in_data[N-1])));

endmodule

// File: tb/shrot_reg_top_tb.sv
module shrot_reg_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int CW = 4;
   localparam int NV = 31;

   // {req[3:0], op[2:0], data[7:0], count[3:0], cin, exp_data[7:0], exp_cy}
   localparam logic [28:0] VEC [NV] = '{
      {4'd1,  3'd0, 8'h3B, 4'd2,  1'b1, 8'hEC, 1'b0},  // R1
      {4'd1,  3'd0, 8'h81, 4'd1,  1'b0, 8'h02, 1'b1},  // R1
      {4'd9,  3'd0, 8'h01, 4'd8,  1'b0, 8'h00, 1'b1},  // R9 count == N
      {4'd9,  3'd0, 8'hFF, 4'd9,  1'b1, 8'h00, 1'b0},  // R9 count > N
      {4'd2,  3'd1, 8'h3B, 4'd2,  1'b0, 8'h0E, 1'b1},  // R2
      {4'd9,  3'd1, 8'h80, 4'd8,  1'b0, 8'h00, 1'b1},  // R9
      {4'd9,  3'd1, 8'hFF, 4'd12, 1'b1, 8'h00, 1'b0},  // R9
      {4'd3,  3'd2, 8'h9C, 4'd2,  1'b1, 8'hE7, 1'b0},  // R3
      {4'd3,  3'd2, 8'h9D, 4'd3,  1'b0, 8'hF3, 1'b1},  // R3
      {4'd9,  3'd2, 8'h80, 4'd10, 1'b0, 8'hFF, 1'b1},  // R9
      {4'd9,  3'd2, 8'h7F, 4'd8,  1'b1, 8'h00, 1'b0},  // R9
      {4'd4,  3'd3, 8'h96, 4'd3,  1'b1, 8'hB4, 1'b0},  // R4
      {4'd4,  3'd3, 8'h81, 4'd1,  1'b0, 8'h03, 1'b1},  // R4
      {4'd10, 3'd3, 8'h81, 4'd9,  1'b0, 8'h03, 1'b1},  // R10 mod N
      {4'd10, 3'd3, 8'h5A, 4'd8,  1'b1, 8'h5A, 1'b0},  // R10 full turn
      {4'd5,  3'd4, 8'h96, 4'd3,  1'b0, 8'hD2, 1'b1},  // R5
      {4'd5,  3'd4, 8'h01, 4'd1,  1'b0, 8'h80, 1'b1},  // R5
      {4'd10, 3'd4, 8'h01, 4'd10, 1'b1, 8'h40, 1'b0},  // R10
      {4'd6,  3'd5, 8'h80, 4'd1,  1'b0, 8'h00, 1'b1},  // R6
      {4'd6,  3'd5, 8'h00, 4'd1,  1'b1, 8'h01, 1'b0},  // R6
      {4'd6,  3'd5, 8'h55, 4'd3,  1'b1, 8'hAD, 1'b0},  // R6
      {4'd10, 3'd5, 8'h55, 4'd9,  1'b1, 8'h55, 1'b1},  // R10 count == N+1
      {4'd10, 3'd5, 8'h80, 4'd10, 1'b0, 8'h00, 1'b1},  // R10
      {4'd7,  3'd6, 8'h01, 4'd1,  1'b0, 8'h00, 1'b1},  // R7
      {4'd7,  3'd6, 8'h00, 4'd1,  1'b1, 8'h80, 1'b0},  // R7
      {4'd7,  3'd6, 8'h55, 4'd3,  1'b1, 8'h6A, 1'b1},  // R7
      {4'd10, 3'd6, 8'h01, 4'd10, 1'b0, 8'h00, 1'b1},  // R10
      {4'd11, 3'd7, 8'hC3, 4'd5,  1'b1, 8'hC3, 1'b1},  // R11
      {4'd11, 3'd7, 8'h3C, 4'd0,  1'b0, 8'h3C, 1'b0},  // R11
      {4'd8,  3'd0, 8'hA5, 4'd0,  1'b1, 8'hA5, 1'b1},  // R8
      {4'd8,  3'd5, 8'hA5, 4'd0,  1'b0, 8'hA5, 1'b0}   // R8
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_op = '0;
   logic [N-1:0]  in_data = '0;
   logic [CW-1:0] in_count = '0;
   logic          in_carry = 1'b0;
   logic          out_valid;
   logic [N-1:0]  out_data;
   logic          out_carry;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shrot_reg_top #(.N(N), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_data(in_data), .in_count(in_count), .in_carry(in_carry),
      .out_valid(out_valid), .out_data(out_data), .out_carry(out_carry)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, strobe over one rising edge, sample at the next falling edge
   task automatic apply(input logic [2:0] op, input logic [N-1:0] d,
                        input logic [CW-1:0] c, input logic ci);
      @(negedge clk);
      in_op = op; in_data = d; in_count = c; in_carry = ci; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R13: reset state
      repeat (3) @(negedge clk);
      check("R13", "out_data in reset", 32'(out_data), 32'h0);
      check("R13", "out_carry in reset", 32'(out_carry), 32'h0);
      check("R13", "out_valid in reset", 32'(out_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[28:25], i);
         apply(v[24:22], v[21:14], v[13:10], v[9]);
         check(tag, "out_data", 32'(out_data), 32'(v[8:1]));
         check(tag, "out_carry", 32'(out_carry), 32'(v[0]));
         check(tag, "out_valid", 32'(out_valid), 32'h1);
      end

      // R12: done is a single pulse and outputs hold without a strobe
      apply(3'd0, 8'h3B, 4'd2, 1'b1);
      check("R12", "done after strobe", 32'(out_valid), 32'h1);
      in_op = 3'd1; in_data = 8'hFF; in_count = 4'd1; in_carry = 1'b0;
      @(negedge clk);
      check("R12", "done drops", 32'(out_valid), 32'h0);
      repeat (2) @(negedge clk);
      check("R12", "data held", 32'(out_data), 32'hEC);
      check("R12", "carry held", 32'(out_carry), 32'h0);

      // R13: reset in mid-run clears the outputs
      apply(3'd2, 8'h80, 4'd1, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R13", "data cleared", 32'(out_data), 32'h0);
      check("R13", "valid cleared", 32'(out_valid), 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule